// File: doc/BRIEF.md
# Power-up reset time-out sequencer

This block keeps a processor core in reset after a reset event until two delays have run one after the other. The first is a power-up delay measured in ticks of a slow reference clock. The second is an oscillator settling count measured in cycles of the core clock. Which delays run depends on the kind of event and on the configured oscillator type:

- A power-on pulse or a brown-out pulse can start the sequence.
- A sleep wake-up request can start the sequence.
- A crystal-type or RC oscillator setting changes which delays apply.

The external active-low master reset pin never starts the delays. It only holds the core in reset on top of whatever the sequencer is doing. If the pin is held low until both delays have expired, releasing it lets the core start after the pin synchronizer latency and no further wait.

The block is placed next to the clock and reset logic. The power-on and brown-out pulses come from analog detectors, and the wake request comes from the sleep controller. `core_rst_o` feeds the core's reset, and `busy_o` indicates that a delay is still running.

The oscillator type and the timer enable are treated as static configuration. Both are read when an event arrives and again when the power-up delay ends.

Top module: `rst_timeout_seq`

## Requirements
- R1: While `rst_ni` is low, `core_rst_o` is 1 and `busy_o` is 0. The pin synchronizer is cleared to "pin low".
- R2: A power-on pulse with `pwrt_en_ni`=0 starts the power-up delay. The delay ends on the clock edge that samples the PWRT_TICKS-th high `ref_tick_i` after the pulse edge. In crystal mode (`osc_rc_i`=0) the settling count follows.
- R3: The settling count keeps `busy_o` high for exactly OST_CYCLES clock edges after the edge that entered it. On the last of those edges, `busy_o` goes to 0, and `core_rst_o` goes to 0 if the pin is high.
- R4: A power-on pulse with `pwrt_en_ni`=1 in crystal mode runs only the settling count, starting at the pulse edge.
- R5: In RC mode (`osc_rc_i`=1), a power-on pulse runs only the power-up delay when `pwrt_en_ni`=0. When `pwrt_en_ni`=1 it runs nothing, so `busy_o` stays 0. RC mode never runs the settling count.
- R6: A brown-out pulse always runs the power-up delay, whatever the value of `pwrt_en_ni`. In crystal mode the settling count follows.
- R7: A wake request while idle runs only the settling count in crystal mode and has no effect in RC mode.
- R8: A wake request while a delay is running is ignored; the running delay ends at its original time.
- R9: A power-on or brown-out pulse during a running sequence restarts it from the beginning with cleared counters. When both pulses arrive in the same cycle, the power-on rule applies.
- R10: `core_rst_o` is 1 whenever `busy_o` is 1 or the synchronized pin is low. The pin passes through SYNC_STAGES flops, so with the default of 2 a pin change reaches `core_rst_o` on the third clock edge. A pin change never starts or restarts a delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core (oscillator) clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the sequencer logic |
| ref_tick_i | input | 1 | One-cycle tick of the slow reference clock |
| por_pulse_i | input | 1 | Power-on reset event pulse |
| bor_pulse_i | input | 1 | Brown-out reset event pulse |
| wake_req_i | input | 1 | Wake-up from sleep request pulse |
| mclr_ni | input | 1 | External master reset pin, active low, asynchronous |
| osc_rc_i | input | 1 | Oscillator type: 1 = RC, 0 = crystal-type |
| pwrt_en_ni | input | 1 | Power-up delay enable, active low |
| core_rst_o | output | 1 | 1 holds the core in reset |
| busy_o | output | 1 | 1 while a delay is running |

## Verification
An event pulse driven before clock edge N makes `busy_o` change after edge N. That is one register stage, because the state, `busy_o` and `core_rst_o` all come from flops loaded at the same edge.

The power-up delay ends on the edge that samples its last tick. The settling count ends OST_CYCLES edges after it began. A pin change appears on `core_rst_o` SYNC_STAGES+1 edges after it is driven.

The driver counts edges itself, and it queues each expected output pair tagged with the edge number at which it is due. The monitor compares the pair at the falling edge after that numbered rising edge, so every sample lands where the count of registers says the value is due.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_PWRT = 2'd1,
    SEQ_OST  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/rst_seq_counter.sv
// Terminal counter shared by the power-up delay and the settling count.
module rst_seq_counter #(
  parameter int LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic done_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (en_i) begin
      cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i || en_i) begin
      cnt_q <= cnt_d;
    end
  end

  assign done_o = en_i && (cnt_q == LAST);

  // R3: the count never passes its terminal value
  p_cnt_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/rst_pin_sync.sv
// Synchronizer chain for the asynchronous master reset pin.
module rst_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic pin_o
);
  logic [STAGES-1:0] sync_q, sync_d;

  generate
    if (STAGES == 1) begin : g_single
      assign sync_d = pin_i;
    end else begin : g_chain
      assign sync_d = {sync_q[STAGES-2:0], pin_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign pin_o = sync_q[STAGES-1];
endmodule

// File: rtl/rst_timeout_seq.sv
module rst_timeout_seq
  import rst_seq_pkg::*;
#(
  parameter int PWRT_TICKS  = 72,
  parameter int OST_CYCLES  = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_tick_i,
  input  logic por_pulse_i,
  input  logic bor_pulse_i,
  input  logic wake_req_i,
  input  logic mclr_ni,
  input  logic osc_rc_i,
  input  logic pwrt_en_ni,
  output logic core_rst_o,
  output logic busy_o
);
  seq_state_e state_q, state_d;
  logic       core_rst_q, core_rst_d;
  logic       xtal_mode, pwrt_on, restart, wake_ok;
  logic       pwrt_clr, pwrt_en, pwrt_done;
  logic       ost_clr, ost_en, ost_done;
  logic       mclr_s;

  assign xtal_mode = !osc_rc_i;
  assign pwrt_on   = !pwrt_en_ni;
  assign restart   = por_pulse_i || bor_pulse_i;
  assign wake_ok   = wake_req_i && (state_q == SEQ_IDLE) && xtal_mode;

  // Counter controls depend on inputs and present state only.
  assign pwrt_clr = restart;
  assign pwrt_en  = (state_q == SEQ_PWRT) && ref_tick_i && !restart;
  assign ost_en   = (state_q == SEQ_OST) && !restart;
  assign ost_clr  = (state_d == SEQ_OST) && ((state_q != SEQ_OST) || restart);

  always_comb begin
    state_d = state_q;
    if (por_pulse_i) begin
      if (pwrt_on)        state_d = SEQ_PWRT;
      else if (xtal_mode) state_d = SEQ_OST;
      else                state_d = SEQ_IDLE;
    end else if (bor_pulse_i) begin
      state_d = SEQ_PWRT;
    end else if (wake_ok) begin
      state_d = SEQ_OST;
    end else begin
      case (state_q)
        SEQ_PWRT: if (pwrt_done) state_d = xtal_mode ? SEQ_OST : SEQ_IDLE;
        SEQ_OST:  if (ost_done)  state_d = SEQ_IDLE;
        default:  state_d = state_q;
      endcase
    end
  end

  assign core_rst_d = (state_d != SEQ_IDLE) || !mclr_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= SEQ_IDLE;
      core_rst_q <= 1'b1;
    end else begin
      state_q    <= state_d;
      core_rst_q <= core_rst_d;
    end
  end

  rst_seq_counter #(.LIMIT(PWRT_TICKS)) u_pwrt_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (pwrt_clr),
    .en_i   (pwrt_en),
    .done_o (pwrt_done)
  );

  rst_seq_counter #(.LIMIT(OST_CYCLES)) u_ost_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (ost_clr),
    .en_i   (ost_en),
    .done_o (ost_done)
  );

  rst_pin_sync #(.STAGES(SYNC_STAGES)) u_mclr_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (mclr_ni),
    .pin_o  (mclr_s)
  );

  assign core_rst_o = core_rst_q;
  assign busy_o     = (state_q != SEQ_IDLE);

  // R10: a running delay always keeps the core in reset
  p_busy_holds_rst_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> core_rst_o);

  // R10: a low synchronized pin forces reset at the next edge
  p_pin_holds_rst_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mclr_s |=> core_rst_o);

  // R6: a brown-out pulse always enters the power-up delay
  p_bor_enters_pwrt_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bor_pulse_i && !por_pulse_i) |=> (state_q == SEQ_PWRT));

  // R5 R7: the settling count is only ever entered in crystal mode
  p_ost_needs_xtal_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == SEQ_OST) && ($past(state_q) != SEQ_OST)) |-> !$past(osc_rc_i));

  // R8: a wake request does not disturb a running power-up delay
  p_wake_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_req_i && !restart && (state_q == SEQ_PWRT) && !ref_tick_i)
      |=> (state_q == SEQ_PWRT));
endmodule

// File: tb/rst_timeout_seq_test.sv
module rst_timeout_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int PT = 6;
  localparam int OC = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_tick = 1'b0, por = 1'b0, bor = 1'b0, wake = 1'b0;
  logic mclr_n = 1'b1, osc_rc = 1'b0, pwrt_en_n = 1'b0;
  logic core_rst, busy;

  int cyc = 0;
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    int    due;
    bit    rst;
    bit    busy;
    string req;
  } exp_t;
  exp_t q[$];

  rst_timeout_seq #(.PWRT_TICKS(PT), .OST_CYCLES(OC), .SYNC_STAGES(2)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ref_tick_i(ref_tick), .por_pulse_i(por),
    .bor_pulse_i(bor), .wake_req_i(wake), .mclr_ni(mclr_n), .osc_rc_i(osc_rc),
    .pwrt_en_ni(pwrt_en_n), .core_rst_o(core_rst), .busy_o(busy));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit gr, input bit gb, input bit er, input bit eb, input string r);
    n_run++;
    if (gr !== er || gb !== eb) begin
      n_fail++;
      $display("FAIL %s at edge %0d: core_rst/busy got %0b/%0b expected %0b/%0b",
               r, cyc, gr, gb, er, eb);
    end
  endtask

  // Monitor: compare each queued item at the falling edge after its due edge
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      check(core_rst, busy, e.rst, e.busy, e.req);
    end
  end

  task automatic expect_at(input int d, input bit r, input bit b, input string req);
    exp_t e;
    e.due = cyc + d; e.rst = r; e.busy = b; e.req = req;
    q.push_back(e);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic evt(input bit p, input bit b, input bit w);
    por = p; bor = b; wake = w;
    @(negedge clk);
    por = 1'b0; bor = 1'b0; wake = 1'b0;
  endtask

  task automatic tick();
    ref_tick = 1'b1;
    @(negedge clk);
    ref_tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  // Ends a power-up delay with its last tick; xtal adds the settling count
  task automatic last_tick(input bit xtal, input string req);
    if (xtal) begin
      expect_at(OC, 1, 1, req);
      expect_at(OC + 1, 0, 0, req);
    end else begin
      expect_at(1, 0, 0, req);
    end
    tick();
    wait_cyc(OC + 2);
  endtask

  initial begin
    @(negedge clk);
    check(core_rst, busy, 1, 0, "R1");
    wait_cyc(2);
    check(core_rst, busy, 1, 0, "R1");
    rst_n = 1'b1;
    // R10: pin high reaches core_rst on the third edge
    expect_at(2, 1, 0, "R10");
    expect_at(3, 0, 0, "R10");
    wait_cyc(5);

    // R2 R3: power-on, crystal, delay enabled
    osc_rc = 1'b0; pwrt_en_n = 1'b0;
    expect_at(1, 1, 1, "R2");
    evt(1, 0, 0);
    ticks(PT - 1);
    expect_at(30, 1, 1, "R2");
    wait_cyc(30);
    last_tick(1, "R3");

    // R4: power-on, crystal, delay disabled
    pwrt_en_n = 1'b1;
    expect_at(OC, 1, 1, "R4");
    expect_at(OC + 1, 0, 0, "R4");
    evt(1, 0, 0);
    wait_cyc(OC + 2);

    // R5: RC, delay enabled
    osc_rc = 1'b1; pwrt_en_n = 1'b0;
    expect_at(1, 1, 1, "R5");
    evt(1, 0, 0);
    ticks(PT - 1);
    last_tick(0, "R5");

    // R5: RC, delay disabled gives no delay at all
    pwrt_en_n = 1'b1;
    expect_at(1, 0, 0, "R5");
    expect_at(2, 0, 0, "R5");
    evt(1, 0, 0);
    wait_cyc(3);

    // R6: brown-out in RC with delay disabled still runs the delay
    expect_at(1, 1, 1, "R6");
    evt(0, 1, 0);
    ticks(PT - 1);
    last_tick(0, "R6");

    // R6: brown-out in crystal mode adds the settling count
    osc_rc = 1'b0;
    expect_at(1, 1, 1, "R6");
    evt(0, 1, 0);
    ticks(PT - 1);
    last_tick(1, "R6");

    // R7: wake in crystal mode runs settling count only
    expect_at(OC, 1, 1, "R7");
    expect_at(OC + 1, 0, 0, "R7");
    evt(0, 0, 1);
    wait_cyc(OC + 2);

    // R7: wake in RC mode has no effect
    osc_rc = 1'b1;
    expect_at(1, 0, 0, "R7");
    expect_at(2, 0, 0, "R7");
    evt(0, 0, 1);
    wait_cyc(3);

    // R8: wake during the settling count keeps the original end time
    osc_rc = 1'b0; pwrt_en_n = 1'b1;
    expect_at(1, 1, 1, "R8");
    evt(1, 0, 0);
    wait_cyc(9);
    expect_at(10, 1, 1, "R8");
    expect_at(11, 0, 0, "R8");
    evt(0, 0, 1);
    wait_cyc(12);

    // R9: brown-out mid-delay restarts from a cleared count
    pwrt_en_n = 1'b0;
    expect_at(1, 1, 1, "R9");
    evt(1, 0, 0);
    ticks(PT - 2);
    expect_at(1, 1, 1, "R9");
    evt(0, 1, 0);
    ticks(PT - 1);
    expect_at(30, 1, 1, "R9");
    wait_cyc(30);
    last_tick(1, "R9");

    // R9: simultaneous pulses follow the power-on rule (RC, disabled: none)
    osc_rc = 1'b1; pwrt_en_n = 1'b1;
    expect_at(1, 0, 0, "R9");
    evt(1, 1, 0);
    wait_cyc(3);

    // R10: pin low holds reset; delays expire underneath; release is immediate
    osc_rc = 1'b0; pwrt_en_n = 1'b0;
    expect_at(2, 0, 0, "R10");
    expect_at(3, 1, 0, "R10");
    mclr_n = 1'b0;
    wait_cyc(4);
    expect_at(1, 1, 1, "R10");
    evt(1, 0, 0);
    ticks(PT - 1);
    expect_at(OC + 1, 1, 0, "R10");
    tick();
    wait_cyc(OC + 5);
    expect_at(2, 1, 0, "R10");
    expect_at(3, 0, 0, "R10");
    expect_at(8, 0, 0, "R10");
    mclr_n = 1'b1;
    wait_cyc(10);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule